// File: doc/BRIEF.md
# Four-Mode Addressable Bit Latch

This block is an eight-bit storage register where any single bit can be written on its own. It has one data line and a three-bit bit-select address. Two active-low controls pick the mode. With the write enable low and the clear control high, the chosen bit takes the data value. With both controls high, the register holds its contents. With both controls low, the block acts as a one-hot demultiplexer: the chosen bit takes the data value and every other bit is cleared. With the enable high and the clear control low, all bits are zeroed. The stored bits drive the parallel output directly.

The block is a synchronous model of a level-sensitive latch. Each rising clock edge samples the controls, the address and the data, and loads the result into the state register. The value a bit keeps is therefore the data sampled at the last edge before the enable returns high.

Moving the address while the enable is active can briefly select a wrong bit. Address changes belong in hold mode. A sticky flag records any address change seen across two consecutive enabled samples, and an acknowledge input clears the flag.

The inputs are sampled on every edge and there is no back-pressure. Data and controls are plain level pins, with no valid/ready pair.

Top module: `addr_bit_latch`

## Requirements
- R1: A synchronous reset (rst_n low at an edge) makes q all zero and clears addr_chg.
- R2: Write mode (en_n=0, clr_n=1): after the edge, q[addr] equals din and every other bit of q is unchanged.
- R3: Hold mode (en_n=1, clr_n=1): after the edge, q is unchanged whatever addr and din are.
- R4: Demultiplex mode (en_n=0, clr_n=0): after the edge, q equals din shifted left by addr. This is the one-hot code of addr when din=1 and all zeros when din=0.
- R5: Clear mode (en_n=1, clr_n=0): after the edge, q is all zero whatever addr and din are.
- R6: After a demultiplex edge, following hold edges keep showing the decoded pattern on q.
- R7: addr_chg is set after an edge at which en_n is low, en_n was also low at the previous edge, and addr differs from the address sampled at that previous edge.
- R8: Address changes while en_n is high, and the first enabled edge that follows a disabled edge, do not set addr_chg.
- R9: addr_chg stays set until an edge with ack=1 and no new set condition clears it. When a set condition and ack occur at the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Clear control, active low |
| addr | input | 3 | Bit-select address |
| din | input | 1 | Data bit |
| ack | input | 1 | Clears the address-change flag |
| q | output | 8 | Stored bits |
| addr_chg | output | 1 | Sticky flag for an address change while enabled |

## Verification
Every result of this block is due one clock edge after the inputs that cause it are sampled. This applies to the stored bits in all four modes and to the flag's set and clear. The bench drives its inputs at the falling edge and waits for the next rising edge. Two time units later it compares the outputs with a reference model that it advanced by exactly one step. A demultiplex pattern is observed again only after further hold edges. Flag results are compared edge by edge, so a one-cycle-late set or a missed clear shows up as a miscompare.

// File: rtl/abl_pkg.sv
package abl_pkg;
  // Mode code is {en_n, clr_n}.
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_HOLD  = 2'b11
  } abl_mode_e;
endpackage

// File: rtl/abl_mode_dec.sv
module abl_mode_dec #(
  parameter int WIDTH = 8,
  localparam int AW = $clog2(WIDTH)
) (
  input  logic                 en_n,
  input  logic                 clr_n,
  input  logic [AW-1:0]        addr,
  output abl_pkg::abl_mode_e   mode,
  output logic [WIDTH-1:0]     sel
);
  assign mode = abl_pkg::abl_mode_e'({en_n, clr_n});

  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign sel[i] = (addr == AW'(i));
  end
endmodule

// File: rtl/abl_store.sv
module abl_store #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  abl_pkg::abl_mode_e mode,
  input  logic [WIDTH-1:0]   sel,
  input  logic               din,
  output logic [WIDTH-1:0]   q
);
  import abl_pkg::*;

  logic [WIDTH-1:0] q_nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (mode)
        MODE_WRITE: q_nxt[i] = sel[i] ? din : q[i];
        MODE_HOLD:  q_nxt[i] = q[i];
        MODE_DEMUX: q_nxt[i] = sel[i] & din;
        default:    q_nxt[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_write_others_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_WRITE) |=> (((q ^ $past(q)) & ~$past(sel)) == '0));
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(q));
  p_demux_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DEMUX) |=> $onehot0(q));
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLEAR) |=> (q == '0));
endmodule

// File: rtl/abl_addr_watch.sv
module abl_addr_watch #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic [AW-1:0] addr,
  input  logic          ack,
  output logic          flag
);
  logic [AW-1:0] prev_addr;
  logic          prev_en;
  logic          hit;

  assign hit = !en_n && prev_en && (addr != prev_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_en   <= 1'b0;
      flag      <= 1'b0;
    end else begin
      prev_addr <= addr;
      prev_en   <= !en_n;
      flag      <= hit | (flag & ~ack);
    end
  end

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !en_n && !$past(en_n) && (addr != $past(addr))) |=> flag);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack) |=> flag);
  p_flag_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && en_n) |=> !flag);
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch #(
  parameter int WIDTH = 8,
  localparam int AW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n,
  input  logic             clr_n,
  input  logic [AW-1:0]    addr,
  input  logic             din,
  input  logic             ack,
  output logic [WIDTH-1:0] q,
  output logic             addr_chg
);
  abl_pkg::abl_mode_e mode;
  logic [WIDTH-1:0]   sel;

  abl_mode_dec #(.WIDTH(WIDTH)) u_dec (
    .en_n(en_n), .clr_n(clr_n), .addr(addr), .mode(mode), .sel(sel)
  );

  abl_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .din(din), .q(q)
  );

  abl_addr_watch #(.AW(AW)) u_watch (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .addr(addr), .ack(ack), .flag(addr_chg)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (q == '0) && !addr_chg);
endmodule

// File: tb/addr_bit_latch_tb.sv
module addr_bit_latch_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, en_n, clr_n, din, ack;
  logic [2:0] addr;
  logic [7:0] q;
  logic       addr_chg;

  int vectors = 0;
  int errors  = 0;

  logic [7:0] m_q;
  logic       m_flag, m_pen;
  logic [2:0] m_paddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_bit_latch u_dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .clr_n(clr_n), .addr(addr),
    .din(din), .ack(ack), .q(q), .addr_chg(addr_chg)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic chk_q(string tag, logic [7:0] exp);
    vectors++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s q actual=%h expected=%h", tag, q, exp);
    end
  endtask

  task automatic chk_f(string tag, logic exp);
    vectors++;
    if (addr_chg !== exp) begin
      errors++;
      $display("FAIL %s addr_chg actual=%b expected=%b", tag, addr_chg, exp);
    end
  endtask

  // Drive one vector, advance the model one edge, sample after the edge.
  task automatic step(logic e, logic c, logic [2:0] a, logic d, logic k);
    logic hit;
    @(negedge clk);
    en_n = e; clr_n = c; addr = a; din = d; ack = k;
    @(posedge clk);
    hit = !e && m_pen && (a != m_paddr);
    case ({e, c})
      2'b01:   m_q[a] = d;
      2'b11:   ;
      2'b00:   m_q = {7'b0, d} << a;
      default: m_q = 8'h00;
    endcase
    m_flag  = hit | (m_flag & ~k);
    m_pen   = !e;
    m_paddr = a;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en_n = 1'b1; clr_n = 1'b1; addr = 3'd0; din = 1'b0; ack = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    m_q = 8'h00; m_flag = 1'b0; m_pen = 1'b0; m_paddr = 3'd0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    chk_q("R1", 8'h00);
    chk_f("R1", 1'b0);

    // Near-exhaustive sweep: every mode x address x data, with a refill write in between.
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < 8; a++) begin
          for (int d = 0; d < 2; d++) begin
            logic [2:0] aa;
            string tg;
            aa = (p == 0) ? 3'(a) : 3'(7 - a);
            step(1'b0, 1'b1, 3'((a * 3 + p + d) & 7), 1'((a ^ m ^ d) & 1), 1'b0);
            chk_q("R2", m_q);
            chk_f("R7", m_flag);
            step(m[1], m[0], aa, d[0], 1'((a + d + m) % 3 == 0));
            case (m)
              0: tg = "R4";
              1: tg = "R2";
              2: tg = "R5";
              default: tg = "R3";
            endcase
            chk_q(tg, m_q);
            chk_f("R9", m_flag);
          end
        end
      end
    end

    // Demux pattern persists through hold, even with address and data moving.
    step(1'b1, 1'b1, 3'd0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 3'd5, 1'b1, 1'b1);
    chk_q("R4", 8'h20);
    step(1'b1, 1'b1, 3'd2, 1'b1, 1'b1);
    step(1'b1, 1'b1, 3'd7, 1'b0, 1'b1);
    chk_q("R6", 8'h20);
    chk_f("R8", 1'b0);

    // Changes under hold, and on the first enabled edge, never set the flag.
    step(1'b1, 1'b1, 3'd1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 3'd6, 1'b0, 1'b0);
    step(1'b0, 1'b1, 3'd3, 1'b1, 1'b0);
    chk_f("R8", 1'b0);
    chk_q("R2", 8'h28);
    // Same address on the next enabled edge: still clear.
    step(1'b0, 1'b1, 3'd3, 1'b0, 1'b0);
    chk_f("R8", 1'b0);
    // Different address while still enabled: set.
    step(1'b0, 1'b1, 3'd4, 1'b1, 1'b0);
    chk_f("R7", 1'b1);
    chk_q("R2", 8'h30);
    // Sticky through hold without ack.
    step(1'b1, 1'b1, 3'd0, 1'b0, 1'b0);
    chk_f("R9", 1'b1);
    // Set and ack on the same edge: set wins.
    step(1'b0, 1'b0, 3'd1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 3'd2, 1'b1, 1'b1);
    chk_f("R9", 1'b1);
    chk_q("R4", 8'h04);
    // Ack alone clears.
    step(1'b1, 1'b1, 3'd2, 1'b0, 1'b1);
    chk_f("R9", 1'b0);
    // Clear mode ignores address and data.
    step(1'b1, 1'b0, 3'd2, 1'b1, 1'b0);
    chk_q("R5", 8'h00);

    // Reset from a loaded state.
    step(1'b0, 1'b1, 3'd7, 1'b1, 1'b0);
    step(1'b0, 1'b1, 3'd0, 1'b1, 1'b0);
    do_reset();
    chk_q("R1", 8'h00);
    chk_f("R1", 1'b0);

    finish_run();
  end
endmodule